// File: doc/BRIEF.md
# Serial Configuration Port with Staged Field Promotion

This block is the programming port of a frequency synthesizer's control logic. A host shifts 32-bit words in over a three-wire serial link (clock, data, load strobe). A rising load strobe copies the collected word into one of six configuration words. The three low bits of the word choose which one. The serial clock and the strobe are treated as ordinary inputs, sampled in the system clock domain, and the block acts on their rising edges.

Some fields are staged. Writing their word only updates the stored copy. The value seen on the outputs changes when configuration word 0 is written next. The output divider select is staged only while a control bit in word 2 is set. Otherwise it applies at once. Every other field applies as soon as its word is loaded. A one-cycle strobe marks each write of word 0 so that downstream counters can restart.

Top module: `synth_serial_regif`

## Requirements
- R1: During reset and directly after it, every field output and `r0_load_o` are zero.
- R2: Each rising edge of `sclk_i` shifts `sdata_i` into the 32-bit word at bit 0, so the first bit sent ends up as bit 31 (MSB first).
- R3: On a rising edge of `le_i`, bits [2:0] of the word (0..5) select the configuration word that is loaded. Field positions are: word 0 int [18:3], frac [30:19]; word 1 phase [14:3], mod [26:15]; word 2 divider-stage enable [13], ref count [23:14], doubler [24], halver [25], current [29:26]; word 3 clock div [14:3]; word 4 out divider [5:3], band div [13:6]; word 5 aux [18:3].
- R4: Words whose bits [2:0] are 6 or 7 change no output and raise no `r0_load_o`.
- R5: Loading word 1 or word 2 leaves phase, mod, ref count, doubler, halver and current outputs unchanged.
- R6: A load of word 0 moves every staged value to its output on the same clock edge that updates int and frac.
- R7: int, frac, divider-stage enable, clock div, band div and aux appear on the outputs on the first clock edge after the load strobe rises.
- R8: With the divider-stage enable (word 2 bit 13) at 0, loading word 4 updates the out divider output at once.
- R9: With the divider-stage enable at 1, loading word 4 leaves the out divider output unchanged until word 0 is next loaded.
- R10: `r0_load_o` is high for exactly one cycle for each load of word 0, in the cycle in which the new values are first visible.
- R11: Holding `le_i` or `sclk_i` high for many cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, sampled |
| sdata_i | input | 1 | Serial data |
| le_i | input | 1 | Load strobe, sampled |
| int_o | output | 16 | Integer divide value |
| frac_o | output | 12 | Fractional value |
| phase_o | output | 12 | Applied phase (staged) |
| mod_o | output | 12 | Applied modulus (staged) |
| ref_cnt_o | output | 10 | Applied reference count (staged) |
| ref_dbl_o | output | 1 | Applied reference doubler (staged) |
| ref_half_o | output | 1 | Applied reference halver (staged) |
| cp_cur_o | output | 4 | Applied current setting (staged) |
| div_sync_o | output | 1 | Divider-stage enable |
| clkdiv_o | output | 12 | Clock divider value |
| out_div_o | output | 3 | Applied output divider select |
| band_div_o | output | 8 | Band select clock divider |
| aux_o | output | 16 | Auxiliary field |
| r0_load_o | output | 1 | One-cycle strobe on each word 0 load |

## Verification
The bench targets staged fields that leak through early. A design with that fault shows the new modulus or reference count before word 0 is loaded. It also checks the divider select in both settings of the stage enable, so a design that ignores the enable bit either holds the divider when it should not or lets it through when it should be held. Reserved addresses 6 and 7 are sent with all-ones payloads, which exposes a decoder that folds them onto a real word. A strobe held high for several cycles must give exactly one load and one pulse, where a level-sensitive design would repeat the load. A word 0 load is watched cycle by cycle to confirm that the staged and the immediate fields and the pulse change together.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned NUM_REGS = 6;

  // word 0
  localparam int unsigned INT_LSB  = 3;
  localparam int unsigned INT_W    = 16;
  localparam int unsigned FRAC_LSB = 19;
  localparam int unsigned FRAC_W   = 12;
  // word 1
  localparam int unsigned PH_LSB   = 3;
  localparam int unsigned PH_W     = 12;
  localparam int unsigned MOD_LSB  = 15;
  localparam int unsigned MOD_W    = 12;
  // word 2
  localparam int unsigned SYNC_BIT = 13;
  localparam int unsigned REF_LSB  = 14;
  localparam int unsigned REF_W    = 10;
  localparam int unsigned DBL_BIT  = 24;
  localparam int unsigned HALF_BIT = 25;
  localparam int unsigned CP_LSB   = 26;
  localparam int unsigned CP_W     = 4;
  // word 3
  localparam int unsigned CKD_LSB  = 3;
  localparam int unsigned CKD_W    = 12;
  // word 4
  localparam int unsigned DIV_LSB  = 3;
  localparam int unsigned DIV_W    = 3;
  localparam int unsigned BAND_LSB = 6;
  localparam int unsigned BAND_W   = 8;
  // word 5
  localparam int unsigned AUX_LSB  = 3;
  localparam int unsigned AUX_W    = 16;

  typedef struct packed {
    logic [PH_W-1:0]  phase;
    logic [MOD_W-1:0] modv;
    logic [REF_W-1:0] ref_cnt;
    logic             dbl;
    logic             half;
    logic [CP_W-1:0]  cp;
  } staged_t;
endpackage

// File: rtl/sri_shift.sv
module sri_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic              sclk_q, le_q;
  logic [WORD_W-1:0] sr_q;
  logic              sclk_rise;

  assign sclk_rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      le_q   <= le_i;
      if (sclk_rise) sr_q <= {sr_q[WORD_W-2:0], sdata_i};
    end
  end

  assign word_o = sr_q;
  assign load_o = le_i & ~le_q;
endmodule

// File: rtl/sri_regbank.sv
module sri_regbank #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NUM_REGS = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [WORD_W-1:0]                word_i,
  output logic [NUM_REGS-1:0]              wr_o,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_o
);
  logic [ADDR_W-1:0] addr;
  assign addr = word_i[ADDR_W-1:0];

  // codes at or above NUM_REGS match no slot
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    assign wr_o[k] = load_i && (addr == ADDR_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_o[k] <= '0;
      else if (wr_o[k]) regs_o[k] <= word_i;
    end
  end
endmodule

// File: rtl/sri_promote.sv
module sri_promote
  import sri_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              wr_i,
  input  logic [WORD_W-1:0]                word_i,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]  regs_i,
  output staged_t                          act_o,
  output logic [DIV_W-1:0]                 div_o,
  output logic                             pulse_o
);
  staged_t          pend;
  logic             div_staged;
  logic [WORD_W-1:0] w1, w2, w4;

  assign w1 = regs_i[1];
  assign w2 = regs_i[2];
  assign w4 = regs_i[4];
  assign div_staged = w2[SYNC_BIT];

  always_comb begin
    pend.phase   = w1[PH_LSB +: PH_W];
    pend.modv    = w1[MOD_LSB +: MOD_W];
    pend.ref_cnt = w2[REF_LSB +: REF_W];
    pend.dbl     = w2[DBL_BIT];
    pend.half    = w2[HALF_BIT];
    pend.cp      = w2[CP_LSB +: CP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o   <= '0;
      div_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= wr_i[0];
      if (wr_i[0]) begin
        act_o <= pend;
        div_o <= w4[DIV_LSB +: DIV_W];
      end else if (wr_i[4] && !div_staged) begin
        div_o <= word_i[DIV_LSB +: DIV_W];
      end
    end
  end
endmodule

// File: rtl/synth_serial_regif.sv
module synth_serial_regif
  import sri_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [MOD_W-1:0]  mod_o,
  output logic [REF_W-1:0]  ref_cnt_o,
  output logic              ref_dbl_o,
  output logic              ref_half_o,
  output logic [CP_W-1:0]   cp_cur_o,
  output logic              div_sync_o,
  output logic [CKD_W-1:0]  clkdiv_o,
  output logic [DIV_W-1:0]  out_div_o,
  output logic [BAND_W-1:0] band_div_o,
  output logic [AUX_W-1:0]  aux_o,
  output logic              r0_load_o
);
  logic [WORD_W-1:0]                word;
  logic                             load;
  logic [NUM_REGS-1:0]              wr;
  logic [NUM_REGS-1:0][WORD_W-1:0]  regs;
  staged_t                          act;

  sri_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .le_i(le_i), .word_o(word), .load_o(load)
  );

  sri_regbank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .word_i(word),
    .wr_o(wr), .regs_o(regs)
  );

  sri_promote #(.NUM_REGS(NUM_REGS)) u_prom (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .word_i(word), .regs_i(regs),
    .act_o(act), .div_o(out_div_o), .pulse_o(r0_load_o)
  );

  logic [WORD_W-1:0] w0, w2, w3, w4, w5;
  assign w0 = regs[0];
  assign w2 = regs[2];
  assign w3 = regs[3];
  assign w4 = regs[4];
  assign w5 = regs[5];

  assign int_o      = w0[INT_LSB +: INT_W];
  assign frac_o     = w0[FRAC_LSB +: FRAC_W];
  assign div_sync_o = w2[SYNC_BIT];
  assign clkdiv_o   = w3[CKD_LSB +: CKD_W];
  assign band_div_o = w4[BAND_LSB +: BAND_W];
  assign aux_o      = w5[AUX_LSB +: AUX_W];

  assign phase_o    = act.phase;
  assign mod_o      = act.modv;
  assign ref_cnt_o  = act.ref_cnt;
  assign ref_dbl_o  = act.dbl;
  assign ref_half_o = act.half;
  assign cp_cur_o   = act.cp;
endmodule

// File: rtl/sri_checker.sv
module sri_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        le_i,
  input logic        r0_load_o,
  input logic        div_sync_o,
  input logic [2:0]  out_div_o,
  input logic [39:0] staged_cat,
  input logic [64:0] imm_cat
);
  p_buf_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r0_load_o |-> $stable(staged_cat));

  p_imm_after_le_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(imm_cat) |-> $past(le_i));

  p_pulse_from_le_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r0_load_o |-> $past(le_i));

  p_pulse_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r0_load_o |=> !r0_load_o);

  p_div_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_sync_o) && !r0_load_o) |-> $stable(out_div_o));
endmodule

bind synth_serial_regif sri_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .le_i(le_i), .r0_load_o(r0_load_o),
  .div_sync_o(div_sync_o), .out_div_o(out_div_o),
  .staged_cat({phase_o, mod_o, ref_cnt_o, ref_dbl_o, ref_half_o, cp_cur_o}),
  .imm_cat({int_o, frac_o, div_sync_o, clkdiv_o, band_div_o, aux_o})
);

// File: tb/synth_serial_regif_tb.sv
module synth_serial_regif_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, le_i = 1'b0;
  logic [15:0] int_o, aux_o;
  logic [11:0] frac_o, phase_o, mod_o, clkdiv_o;
  logic [9:0]  ref_cnt_o;
  logic        ref_dbl_o, ref_half_o, div_sync_o, r0_load_o;
  logic [3:0]  cp_cur_o;
  logic [2:0]  out_div_o;
  logic [7:0]  band_div_o;

  always #5 clk_i = ~clk_i;

  synth_serial_regif u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i), .le_i(le_i),
    .int_o(int_o), .frac_o(frac_o), .phase_o(phase_o), .mod_o(mod_o),
    .ref_cnt_o(ref_cnt_o), .ref_dbl_o(ref_dbl_o), .ref_half_o(ref_half_o),
    .cp_cur_o(cp_cur_o), .div_sync_o(div_sync_o), .clkdiv_o(clkdiv_o),
    .out_div_o(out_div_o), .band_div_o(band_div_o), .aux_o(aux_o), .r0_load_o(r0_load_o)
  );

  localparam logic [3:0] S_INT = 0, S_FRAC = 1, S_PH = 2, S_MOD = 3, S_REF = 4,
    S_DBL = 5, S_HALF = 6, S_CP = 7, S_SYNC = 8, S_CKD = 9, S_DIV = 10,
    S_BAND = 11, S_AUX = 12;

  typedef struct packed {
    logic        wr;
    logic [31:0] word;
    logic [3:0]  sel;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h000055E3, S_CKD,  16'h0ABC, 4'd2},  // R2 R3: word 3, MSB-first
    '{1'b1, 32'h0004000D, S_AUX,  16'h8001, 4'd7},  // R7: word 5
    '{1'b1, 32'h07FF8AA9, S_MOD,  16'h0000, 4'd5},  // R5: mod staged
    '{1'b1, 32'h07FF8AA9, S_PH,   16'h0000, 4'd5},  // R5: phase staged
    '{1'b1, 32'h25AA8002, S_REF,  16'h0000, 4'd5},  // R5: ref staged
    '{1'b1, 32'h00001FAC, S_DIV,  16'h0005, 4'd8},  // R8: divider immediate
    '{1'b1, 32'h09180640, S_MOD,  16'h0FFF, 4'd6},  // R6: word 0 promotes
    '{1'b0, 32'h0,        S_PH,   16'h0155, 4'd6},
    '{1'b0, 32'h0,        S_REF,  16'h02AA, 4'd6},
    '{1'b0, 32'h0,        S_DBL,  16'h0001, 4'd6},
    '{1'b0, 32'h0,        S_CP,   16'h0009, 4'd6},
    '{1'b0, 32'h0,        S_HALF, 16'h0000, 4'd6},
    '{1'b1, 32'hFFFFFFFE, S_INT,  16'h00C8, 4'd4},  // R4: code 6
    '{1'b1, 32'hFFFFFFFF, S_FRAC, 16'h0123, 4'd4},  // R4: code 7
    '{1'b0, 32'h0,        S_CKD,  16'h0ABC, 4'd4},
    '{1'b1, 32'h25AAA002, S_SYNC, 16'h0001, 4'd7},  // R7: stage enable
    '{1'b1, 32'h00000454, S_DIV,  16'h0005, 4'd9},  // R9: divider held
    '{1'b0, 32'h0,        S_BAND, 16'h0011, 4'd7},
    '{1'b1, 32'h00000008, S_DIV,  16'h0002, 4'd9},  // R9: released by word 0
    '{1'b0, 32'h0,        S_INT,  16'h0001, 4'd7}
  };

  int total = 0, bad = 0, pulses = 0;

  always @(negedge clk_i) if (rst_ni && r0_load_o) pulses++;

  function automatic logic [15:0] get(input logic [3:0] s);
    case (s)
      S_INT:  get = int_o;
      S_FRAC: get = 16'(frac_o);
      S_PH:   get = 16'(phase_o);
      S_MOD:  get = 16'(mod_o);
      S_REF:  get = 16'(ref_cnt_o);
      S_DBL:  get = 16'(ref_dbl_o);
      S_HALF: get = 16'(ref_half_o);
      S_CP:   get = 16'(cp_cur_o);
      S_SYNC: get = 16'(div_sync_o);
      S_CKD:  get = 16'(clkdiv_o);
      S_DIV:  get = 16'(out_div_o);
      S_BAND: get = 16'(band_div_o);
      default: get = aux_o;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [31:0] w, input int hi);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk_i); sdata_i = w[i];
      @(negedge clk_i); sclk_i = 1'b1;
      repeat (hi) @(negedge clk_i);
      sclk_i = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] w);
    shift_word(w, 2);
    repeat (2) @(negedge clk_i);
    le_i = 1'b1;
    repeat (2) @(negedge clk_i);
    le_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_all_zero(input string req);
    check(req, {int_o, frac_o, phase_o, mod_o}, 32'h0);
    check(req, {ref_cnt_o, ref_dbl_o, ref_half_o, cp_cur_o, div_sync_o, clkdiv_o,
                out_div_o, r0_load_o}, 32'h0);
    check(req, {band_div_o, aux_o}, 32'h0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, hi_cnt;
    repeat (3) @(negedge clk_i);
    check_all_zero("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all_zero("R1");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) send(VECS[v].word);
      check($sformatf("R%0d vec%0d", VECS[v].req, v), 32'(get(VECS[v].sel)),
            32'(VECS[v].exp));
    end
    check("R10 pulses per word-0 load, R4 none on codes 6/7", pulses, 2);

    // R6 R10 R11: same-edge promotion, strobe held high, slow serial clock
    send(32'h00000781);                // word 1: phase 0x0F0, mod 0
    check("R5 phase held", 32'(phase_o), 32'h155);
    shift_word(32'h00000018, 5);        // word 0: int 3 (R11 long sclk high)
    repeat (2) @(negedge clk_i);
    p0 = pulses;
    le_i = 1'b1;
    @(negedge clk_i);
    check("R10 pulse with update", 32'(r0_load_o), 32'h1);
    check("R6 int same edge", 32'(int_o), 32'h3);
    check("R6 phase same edge", 32'(phase_o), 32'h0F0);
    check("R6 mod same edge", 32'(mod_o), 32'h0);
    hi_cnt = 1;
    repeat (6) begin
      @(negedge clk_i);
      if (r0_load_o) hi_cnt++;
    end
    le_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R11 held strobe one pulse", hi_cnt, 1);
    check("R10 pulse count", pulses - p0, 1);

    // R8 again: stage enable cleared -> immediate
    send(32'h00000002);
    send(32'h0000003C);                // out div 7
    check("R8 divider immediate", 32'(out_div_o), 32'h7);

    rst_ni = 1'b0;
    @(negedge clk_i);
    check_all_zero("R1 midrun");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule